// File: doc/BRIEF.md
# Single-Step Shift and Arithmetic Unit

This block is a purely combinational arithmetic and logic unit for a 32-bit datapath. Two two's-complement operands and a 4-bit operation code go in. A result word and three flags come out in the same cycle. The flags are zero, carry-out and signed overflow.

The operation set is fixed. The arithmetic group has add and subtract. The logic group has NAND, OR and a bitwise invert of the first operand. The single-position movers are an arithmetic right shift, logical shifts in both directions and one-bit rotates in both directions. Only the first operand is moved. Any code outside the set gives a defined result of zero with carry and overflow cleared. The unit has no clock and no state. It sits between an operand-select stage and a result register.

Top module: `opsel_alu`

## Requirements
- R1: Code 4'b0000 gives result = A + B modulo 2^32.
- R2: Code 4'b0001 gives result = A - B modulo 2^32.
- R3: Code 4'b0010 gives ~(A & B), code 4'b0011 gives A | B, and code 4'b0100 gives ~A.
- R4: Code 4'b1000 shifts A right by one position and keeps bit 31 of A in bit 31.
- R5: Code 4'b1001 shifts A right by one with a zero in bit 31. Code 4'b1010 shifts A left by one with a zero in bit 0.
- R6: Code 4'b1100 rotates A left by one, so old bit 31 lands in bit 0. Code 4'b1101 rotates A right by one, so old bit 0 lands in bit 31.
- R7: The carry flag is the carry out of bit 31 of A + B on add, and of A + ~B + 1 on subtract. It is 0 for every other code.
- R8: The overflow flag is 1 on add when A and B share a sign that the result does not have. It is 1 on subtract when A and B differ in sign and the result sign differs from A. It is 0 for every other code.
- R9: The zero flag is 1 exactly when all 32 result bits are 0, whatever the code.
- R10: Every code other than the ten listed above gives result 0, carry 0 and overflow 0. The zero flag is therefore 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | First operand, two's complement; the only operand moved by shifts and rotates |
| b_in | input | 32 | Second operand, two's complement |
| op_code | input | 4 | Operation select |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | Result is all zeros |
| carry_flag | output | 1 | Carry out of the top bit on add and subtract |
| ovf_flag | output | 1 | Signed overflow on add and subtract |

## Verification
All sixteen codes are applied over every pair drawn from a set of edge operands: 0, 1, all ones, the most positive and most negative values, and alternating bit patterns. These pairs separate carry from overflow, since all ones plus one carries without overflowing and the two extremes overflow in both directions. They also show whether the sign bit is copied or zero-filled. The alternating patterns reveal a rotate or shift that moves in the wrong direction or drops its end bit. Random operands then spread the comparison across the full word for every code. The undefined codes show that nothing leaks from the arithmetic or shift paths.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_SUB  = 4'b0001,
    OP_NAND = 4'b0010,
    OP_OR   = 4'b0011,
    OP_INV  = 4'b0100,
    OP_SRA  = 4'b1000,
    OP_SRL  = 4'b1001,
    OP_SLL  = 4'b1010,
    OP_ROL  = 4'b1100,
    OP_ROR  = 4'b1101
  } alu_op_e;

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic op_is_logic(input logic [3:0] op);
    return (op == OP_NAND) || (op == OP_OR) || (op == OP_INV);
  endfunction

  function automatic logic op_is_move(input logic [3:0] op);
    return (op == OP_SRA) || (op == OP_SRL) || (op == OP_SLL) ||
           (op == OP_ROL) || (op == OP_ROR);
  endfunction

  // Left-moving codes take their new bit 0 from the fill; right-moving codes fill the top.
  function automatic logic op_moves_left(input logic [3:0] op);
    return (op == OP_SLL) || (op == OP_ROL);
  endfunction

endpackage

// File: rtl/opsel_alu_arith.sv
module opsel_alu_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = wide[W-1:0];
  assign carry = wide[W];
  assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

  always_comb begin
    if (!$isunknown({a, b, sub})) begin
      AST_OVF_SIGN: assert (!ovf || (sub ? (a[MSB] != b[MSB]) : (a[MSB] == b[MSB]))); // R8
      AST_NO_OVF_MIXED: assert (sub || (a[MSB] != b[MSB]) == 1'b0 || !ovf); // R8
    end
  end
endmodule

// File: rtl/opsel_alu_logic.sv
module opsel_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] res
);
  import opsel_alu_pkg::*;

  always_comb begin
    case (op)
      OP_NAND: res = ~(a & b);
      OP_OR:   res = a | b;
      OP_INV:  res = ~a;
      default: res = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({a, op}) && op == OP_INV) begin
      AST_INV_COMPLEMENT: assert ((res ^ a) == {W{1'b1}}); // R3
    end
  end
endmodule

// File: rtl/opsel_alu_shift.sv
module opsel_alu_shift #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [3:0]   op,
  output logic [W-1:0] res
);
  import opsel_alu_pkg::*;

  localparam int MSB = W - 1;

  logic left;
  logic fill_lo;
  logic fill_hi;

  assign left    = op_moves_left(op);
  assign fill_lo = (op == OP_ROL) ? a[MSB] : 1'b0;
  assign fill_hi = (op == OP_SRA) ? a[MSB] :
                   (op == OP_ROR) ? a[0]   : 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_right;
    logic from_left;
    if (i == 0) begin : g_lo
      assign from_right = fill_lo;
    end else begin : g_lo_mid
      assign from_right = a[i-1];
    end
    if (i == MSB) begin : g_hi
      assign from_left = fill_hi;
    end else begin : g_hi_mid
      assign from_left = a[i+1];
    end
    assign res[i] = left ? from_right : from_left;
  end

  always_comb begin
    if (!$isunknown({a, op}) && (op == OP_ROL || op == OP_ROR)) begin
      AST_ROT_KEEPS_ONES: assert ($countones(res) == $countones(a)); // R6
    end
  end
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu #(
  parameter int W = 32
) (
  input  logic [31:0] a_in,
  input  logic [31:0] b_in,
  input  logic [3:0]  op_code,
  output logic [31:0] result,
  output logic        zero_flag,
  output logic        carry_flag,
  output logic        ovf_flag
);
  import opsel_alu_pkg::*;

  logic [W-1:0] arith_sum;
  logic         arith_carry;
  logic         arith_ovf;
  logic [W-1:0] logic_res;
  logic [W-1:0] move_res;
  logic         sel_arith;
  logic         sel_logic;
  logic         sel_move;
  logic         op_known;

  assign sel_arith = op_is_arith(op_code);
  assign sel_logic = op_is_logic(op_code);
  assign sel_move  = op_is_move(op_code);
  assign op_known  = sel_arith | sel_logic | sel_move;

  opsel_alu_arith #(.W(W)) u_arith (
    .a(a_in), .b(b_in), .sub(op_code == OP_SUB),
    .sum(arith_sum), .carry(arith_carry), .ovf(arith_ovf)
  );

  opsel_alu_logic #(.W(W)) u_logic (
    .a(a_in), .b(b_in), .op(op_code), .res(logic_res)
  );

  opsel_alu_shift #(.W(W)) u_shift (
    .a(a_in), .op(op_code), .res(move_res)
  );

  always_comb begin
    result     = '0;
    carry_flag = 1'b0;
    ovf_flag   = 1'b0;
    if (sel_arith) begin
      result     = arith_sum;
      carry_flag = arith_carry;
      ovf_flag   = arith_ovf;
    end else if (sel_logic) begin
      result = logic_res;
    end else if (sel_move) begin
      result = move_res;
    end
  end

  assign zero_flag = (result == '0);

  always_comb begin
    if (!$isunknown({a_in, b_in, op_code})) begin
      AST_ONE_GROUP: assert ($countones({sel_arith, sel_logic, sel_move}) <= 1); // R10
      AST_NO_FLAGS_OFF_ARITH: assert (sel_arith || (!carry_flag && !ovf_flag)); // R7
      AST_UNDEF_ZERO: assert (op_known || (result == '0 && zero_flag)); // R10
      AST_ZERO_MATCH: assert (zero_flag == ($countones(result) == 0)); // R9
    end
  end
endmodule

// File: tb/opsel_alu_test.sv
module opsel_alu_test;
  logic        clk = 1'b0;
  logic [31:0] a_in, b_in;
  logic [3:0]  op_code;
  logic [31:0] result;
  logic        zero_flag, carry_flag, ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opsel_alu uut (
    .a_in(a_in), .b_in(b_in), .op_code(op_code),
    .result(result), .zero_flag(zero_flag),
    .carry_flag(carry_flag), .ovf_flag(ovf_flag)
  );

  logic [31:0] exp_res;
  logic        exp_c, exp_v;

  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
    longint sa, sb, s;
    longint unsigned ua, ub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'(a);
    ub = longint'(b);
    exp_c = 1'b0;
    exp_v = 1'b0;
    case (op)
      4'd0: begin
        s = sa + sb;
        exp_res = 32'(ua + ub);
        exp_c = ((ua + ub) >= 64'h1_0000_0000);
        exp_v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      4'd1: begin
        s = sa - sb;
        exp_res = 32'(ua - ub);
        exp_c = (ua >= ub);
        exp_v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      4'd2:  exp_res = ~(a & b);
      4'd3:  exp_res = a | b;
      4'd4:  exp_res = 32'hFFFF_FFFF - a;
      4'd8:  exp_res = 32'(sa / 2 - ((sa < 0 && sa % 2 != 0) ? 1 : 0));
      4'd9:  exp_res = 32'(ua / 2);
      4'd10: exp_res = 32'(ua * 2);
      4'd12: exp_res = 32'(ua * 2) + 32'(ua / 64'h8000_0000);
      4'd13: exp_res = 32'(ua / 2) + ((ua % 2 == 1) ? 32'h8000_0000 : 32'h0);
      default: exp_res = 32'h0;
    endcase
  endtask

  function automatic string res_tag(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd8: return "R4";
      4'd9, 4'd10: return "R5";
      4'd12, 4'd13: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input logic [3:0] op);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a_in, b_in, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
    @(posedge clk);
    a_in = a; b_in = b; op_code = op;
    model(a, b, op);
    @(negedge clk);
    check(res_tag(op), result, exp_res, op);
    check("R7", {31'b0, carry_flag}, {31'b0, exp_c}, op);
    check("R8", {31'b0, ovf_flag}, {31'b0, exp_v}, op);
    check("R9", {31'b0, zero_flag}, {31'b0, (exp_res == 32'h0)}, op);
  endtask

  logic [31:0] corner [6];

  initial begin
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h7FFF_FFFF; corner[4] = 32'h8000_0000; corner[5] = 32'h5555_5555;
    a_in = '0; b_in = '0; op_code = '0;
    @(negedge clk);
    // Idle state with all-zero inputs: add of zeros gives zero, zero flag set (R9)
    check("R9", {31'b0, zero_flag}, 32'h1, 4'd0);
    check("R1", result, 32'h0, 4'd0);
    // Directed boundary cases
    apply(32'hFFFF_FFFF, 32'h1, 4'd0);        // R7 carry without overflow
    apply(32'h7FFF_FFFF, 32'h1, 4'd0);        // R8 positive overflow
    apply(32'h8000_0000, 32'h1, 4'd1);        // R8 negative overflow on subtract
    apply(32'h8000_0001, 32'h0, 4'd8);        // R4 sign copy
    apply(32'h8000_0001, 32'h0, 4'd12);       // R6 top bit wraps to bit 0
    apply(32'h8000_0001, 32'h0, 4'd13);       // R6 bit 0 wraps to top
    apply(32'hAAAA_AAAB, 32'hFFFF_FFFF, 4'd7); // R10 undefined code
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(corner[i], corner[j], 4'(op));
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 200; k++)
        apply($urandom, $urandom, 4'(op));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule